// File: doc/BRIEF.md
# IR Receive Run-Length Sampler

This block watches the demodulated output of an infrared receiver and describes it as a stream of run-length bytes. A programmable prescaler divides the system clock into a sampling tick that nominally lasts 10 µs. On every tick the synchronized line level is sampled and added to the current run. When the level changes, the finished run is written as one byte into a 16-entry receive FIFO. The FIFO is drained by a host through a small byte-wide register port.

A long quiet period after a burst produces a fixed batch of all-ones filler bytes and then nothing more. A host that reads a batch made only of filler therefore knows that the burst is over. The host can mask reception at any time. It can also choose whether reception continues while the transmitter on the same chip is busy, and it can invert the receiver polarity. A FIFO level interrupt and an overrun interrupt are combined into one request line under a per-source enable.

Top module: `ir_rle_rx`

## Requirements
- R1: Each FIFO byte describes one run. Bit 7 is 1 for a space (no IR) and 0 for a pulse. Bits 6..0 hold the run length in ticks, from 1 to 127. A pulse is a sampled level of 1 after the optional inversion.
- R2: One tick lasts PRESCALE+1 clocks. PRESCALE is written at register 5 (low byte) and register 6 (high byte) and resets to 999.
- R3: A run longer than 127 ticks is written as 127-tick bytes of the same polarity, followed by one byte holding the remainder.
- R4: Once the last pulse of a burst ends, each further 127 ticks of space write 0xFF, up to 8 bytes. After that, nothing is written until the next pulse. An idle line after reset writes nothing.
- R5: Reading register 0 returns the oldest FIFO byte and removes it from the FIFO. Reading register 0 when the FIFO is empty returns 0. Bit 0 of register 1 is 1 while the FIFO holds data.
- R6: A run that finishes while the 16-entry FIFO is full sets overrun, which is bit 1 of register 1. While overrun is set, new bytes are dropped and the stored bytes stay intact. Reading register 1 clears overrun.
- R7: Register 3 shows the pending interrupt sources: bit 0 means 8 or more bytes are waiting, and bit 2 means overrun. Register 2 holds the enables at the same bit positions. `irq` is high exactly when a pending source has its enable set.
- R8: Register 4 bit 5 set to 1 turns reception off. No bytes are written while it is set.
- R9: Register 4 bit 0 set to 1 inverts `ir_in` before sampling.
- R10: When register 4 bit 1 is 0, reception is off while `tx_busy` is high. When that bit is 1, reception continues while `tx_busy` is high.
- R11: After reset, registers 1, 2, 3 and 4 read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated receiver level, asynchronous |
| tx_busy | input | 1 | Transmitter active, synchronous to clk |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; side effects apply at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions make four assumptions about the inputs:
- Each read or write strobe lasts a single cycle, and the address is held steady while the strobe is high.
- `tx_busy` is already synchronous to the clock.
- The prescaler is not rewritten in the middle of a run.
- Only `ir_in` arrives from another clock domain.

The stimulus follows all of these. It changes registers only between bursts, and only while the line is quiet or reception is off. It holds each line level for a whole number of tick periods, so every run length is an exact tick count. Every burst ends on a pulse, so that the trailing space always produces the filler sequence.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_STAT = 3'd1;
   localparam logic [2:0] A_IEN  = 3'd2;
   localparam logic [2:0] A_IID  = 3'd3;
   localparam logic [2:0] A_CTRL = 3'd4;
   localparam logic [2:0] A_DIVL = 3'd5;
   localparam logic [2:0] A_DIVH = 3'd6;

   localparam int B_RXLVL = 0;
   localparam int B_ERR   = 2;
   localparam int C_INV   = 0;
   localparam int C_TXRX  = 1;
   localparam int C_DIS   = 5;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/ir_sync.sv
module ir_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ir_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/ir_run_encoder.sv
module ir_run_encoder #(
   parameter int DUR_W  = 7,
   parameter int FILL_N = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           enable,
   input  logic           tick,
   input  logic           level,
   output logic           push,
   output logic [DUR_W:0] pbyte
);
   localparam int FW = $clog2(FILL_N + 1);
   localparam logic [DUR_W-1:0] MAXD      = '1;
   localparam logic [DUR_W-1:0] ONE       = DUR_W'(1);
   localparam logic [FW-1:0]    FILL_LAST = FW'(FILL_N - 1);

   generate
      if (DUR_W < 2 || FILL_N < 1) begin : g_bad
         $error("ir_run_encoder parameter out of range");
      end
   endgenerate

   logic             pol;
   logic [DUR_W-1:0] cnt;
   logic             quiet;
   logic [FW-1:0]    fill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol <= 1'b0; cnt <= '0; quiet <= 1'b1; fill <= '0;
         push <= 1'b0; pbyte <= '0;
      end else begin
         push <= 1'b0;
         if (!enable) begin
            pol <= 1'b0; cnt <= '0; quiet <= 1'b1; fill <= '0;
         end else if (tick) begin
            if (quiet) begin
               if (level) begin
                  quiet <= 1'b0; pol <= 1'b1; cnt <= ONE;
               end
            end else if (level != pol) begin
               push  <= 1'b1;
               pbyte <= {~pol, cnt};
               fill  <= '0;
               pol   <= level;
               cnt   <= ONE;
            end else if (cnt == MAXD) begin
               push  <= 1'b1;
               pbyte <= {~pol, cnt};
               cnt   <= ONE;
               if (pol) begin
                  fill <= '0;
               end else if (fill == FILL_LAST) begin
                  quiet <= 1'b1; fill <= '0; cnt <= '0;
               end else begin
                  fill <= fill + 1'b1;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   p_dur_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (pbyte[DUR_W-1:0] != '0));
   p_disabled_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !push);
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   parameter int LEVEL = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   input  logic         ovr_clr,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         level_hit,
   output logic         ovr
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULLC = (AW+1)'(DEPTH);
   localparam logic [AW:0] LVLC  = (AW+1)'(LEVEL);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH || LEVEL < 1 || LEVEL > DEPTH) begin : g_bad
         $error("ir_rx_fifo depth must be a power of two and level within depth");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          full, do_push, do_pop;

   assign full      = (cnt == FULLC);
   assign empty     = (cnt == '0);
   assign level_hit = (cnt >= LVLC);
   assign dout      = mem[rp];
   assign do_push   = push && !ovr && !full;
   assign do_pop    = pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; cnt <= '0; ovr <= 1'b0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (push && full && !ovr) ovr <= 1'b1;
         else if (ovr_clr)         ovr <= 1'b0;
      end
   end

   p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr) |=> ovr);
   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULLC);
   p_drop_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/ir_rle_rx.sv
module ir_rle_rx
   import ir_rle_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int DEFAULT_DIV = 1000,
   parameter int FIFO_DEPTH  = 16,
   parameter int IRQ_LEVEL   = 8,
   parameter int FILL_N      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ir_in,
   input  logic       tx_busy,
   input  logic [2:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq
);
   localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DEFAULT_DIV - 1);

   generate
      if (DIV_W < 9 || DIV_W > 16 || DEFAULT_DIV < 1) begin : g_bad
         $error("ir_rle_rx prescaler parameters out of range");
      end
   endgenerate

   logic [7:0]       ien_q, ctrl_q;
   logic [DIV_W-1:0] div_q;
   logic             tick, line_s, level, rx_on;
   logic             push;
   logic [7:0]       pbyte, fifo_dout;
   logic             empty, lvl_hit, ovr;
   logic             pop, ovr_clr;
   logic [7:0]       iid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0; ctrl_q <= '0; div_q <= DIV_RST;
      end else if (reg_wr) begin
         case (reg_addr)
            A_IEN:   ien_q <= reg_wdata;
            A_CTRL:  ctrl_q <= reg_wdata;
            A_DIVL:  div_q[7:0] <= reg_wdata;
            A_DIVH:  div_q[DIV_W-1:8] <= reg_wdata[DIV_W-9:0];
            default: ;
         endcase
      end
   end

   ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

   ir_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ir_in), .q(line_s));

   assign level = line_s ^ ctrl_q[C_INV];
   assign rx_on = !ctrl_q[C_DIS] && (!tx_busy || ctrl_q[C_TXRX]);

   ir_run_encoder #(.DUR_W(7), .FILL_N(FILL_N)) u_enc (
      .clk(clk), .rst_n(rst_n), .enable(rx_on), .tick(tick), .level(level),
      .push(push), .pbyte(pbyte));

   assign pop     = reg_rd && (reg_addr == A_DATA);
   assign ovr_clr = reg_rd && (reg_addr == A_STAT);

   ir_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .LEVEL(IRQ_LEVEL)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(pbyte), .pop(pop),
      .ovr_clr(ovr_clr), .dout(fifo_dout), .empty(empty),
      .level_hit(lvl_hit), .ovr(ovr));

   always_comb begin
      iid = '0;
      iid[B_RXLVL] = lvl_hit;
      iid[B_ERR]   = ovr;
   end

   assign irq = |(iid & ien_q);

   always_comb begin
      case (reg_addr)
         A_DATA:  reg_rdata = empty ? 8'h00 : fifo_dout;
         A_STAT:  reg_rdata = {6'b0, ovr, !empty};
         A_IEN:   reg_rdata = ien_q;
         A_IID:   reg_rdata = iid;
         A_CTRL:  reg_rdata = ctrl_q;
         A_DIVL:  reg_rdata = div_q[7:0];
         A_DIVH:  reg_rdata = 8'(div_q >> 8);
         default: reg_rdata = 8'h00;
      endcase
   end

   p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien_q[B_RXLVL] || ien_q[B_ERR]));
endmodule

// File: tb/ir_rle_rx_test.sv
module ir_rle_rx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ir_in = 1'b0;
   logic       tx_busy = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq;

   localparam int TP = 4;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;
   bit   inv_b = 0;
   bit   exp_on = 1;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   ir_rle_rx uut (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .tx_busy(tx_busy),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   // driver: one line segment, expected run bytes pushed to the scoreboard (R1, R3)
   task automatic seg(input bit pulse, input int ticks);
      int left = ticks;
      ir_in = pulse ^ inv_b;
      if (exp_on) begin
         while (left > 127) begin
            exp_q.push_back({~pulse, 7'h7F});
            left -= 127;
         end
         exp_q.push_back({~pulse, 7'(left)});
      end
      repeat (ticks * TP) @(negedge clk);
   endtask

   // trailing quiet line: eight 0xFF fillers then silence (R4)
   task automatic tail();
      ir_in = inv_b;
      if (exp_on) for (int i = 0; i < 8; i++) exp_q.push_back(8'hFF);
      repeat (1100 * TP) @(negedge clk);
   endtask

   // monitor: drain FIFO while data available, compare with scoreboard (R5)
   task automatic drain(input string req);
      logic [7:0] s, d, e;
      rd(3'd1, s);
      while (s[0]) begin
         rd(3'd0, d);
         if (exp_q.size() == 0) begin
            chk(req, d, 8'hxx);
         end else begin
            e = exp_q.pop_front();
            chk(req, d, e);
         end
         rd(3'd1, s);
      end
      chk({req, " leftover"}, 8'(exp_q.size()), 8'd0);
      exp_q.delete();
   endtask

   task automatic burst_a();
      seg(1, 5); seg(0, 3); seg(1, 7); tail();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state, R2 prescaler reset value
      rd(3'd1, v); chk("R11 status", v, 8'h00);
      rd(3'd2, v); chk("R11 ien", v, 8'h00);
      rd(3'd3, v); chk("R11 iid", v, 8'h00);
      rd(3'd4, v); chk("R11 ctrl", v, 8'h00);
      chk("R11 irq", {7'b0, irq}, 8'h00);
      rd(3'd5, v); chk("R2 div low reset", v, 8'hE7);
      rd(3'd6, v); chk("R2 div high reset", v, 8'h03);
      rd(3'd0, v); chk("R5 empty read", v, 8'h00);

      // R2 program tick of TP clocks
      wr(3'd5, 8'(TP - 1)); wr(3'd6, 8'h00);
      rd(3'd5, v); chk("R2 div low", v, 8'(TP - 1));

      // R4 idle line after reset writes nothing
      repeat (200 * TP) @(negedge clk);
      rd(3'd1, v); chk("R4 idle after reset", v, 8'h00);

      // R1 R4 R7 basic burst with level interrupt
      wr(3'd2, 8'h01);
      burst_a();
      chk("R7 irq level", {7'b0, irq}, 8'h01);
      rd(3'd3, v); chk("R7 iid level", v, 8'h01);
      wr(3'd2, 8'h00);
      chk("R7 irq masked", {7'b0, irq}, 8'h00);
      drain("R1 burst");
      rd(3'd3, v); chk("R7 iid after drain", v, 8'h00);

      // R3 long run split
      seg(1, 130); seg(0, 2); seg(1, 1); tail();
      drain("R3 split");

      // R8 disable: nothing recorded
      wr(3'd4, 8'h20);
      exp_on = 0; burst_a(); exp_on = 1;
      rd(3'd1, v); chk("R8 disabled status", v, 8'h00);

      // R9 inversion, switched while reception is off
      ir_in = 1'b1; inv_b = 1;
      repeat (4) @(negedge clk);
      wr(3'd4, 8'h01);
      repeat (10 * TP) @(negedge clk);
      rd(3'd1, v); chk("R9 inverted idle", v, 8'h00);
      seg(1, 4); seg(0, 9); seg(1, 2); tail();
      drain("R9 invert");
      wr(3'd4, 8'h20);
      ir_in = 1'b0; inv_b = 0;
      repeat (4) @(negedge clk);

      // R10 masked during transmit
      wr(3'd4, 8'h00);
      tx_busy = 1'b1;
      exp_on = 0; burst_a(); exp_on = 1;
      rd(3'd1, v); chk("R10 masked during tx", v, 8'h00);
      wr(3'd4, 8'h02);
      burst_a();
      drain("R10 rx during tx");
      tx_busy = 1'b0;
      wr(3'd4, 8'h00);

      // R6 overrun
      wr(3'd2, 8'h04);
      for (int i = 0; i < 8; i++) begin seg(1, 2); seg(0, 2); end
      exp_on = 0;
      seg(1, 2); seg(0, 2); seg(1, 2); tail();
      exp_on = 1;
      chk("R7 irq overrun", {7'b0, irq}, 8'h01);
      rd(3'd3, v); chk("R7 iid overrun", v, 8'h05);
      rd(3'd1, v); chk("R6 status overrun", v, 8'h03);
      rd(3'd1, v); chk("R6 overrun cleared", v, 8'h01);
      chk("R6 irq after clear", {7'b0, irq}, 8'h00);
      drain("R6 kept contents");
      burst_a();
      drain("R6 accepts after clear");

      finish_run();
   end
endmodule